// File: doc/BRIEF.md
# Direct-Mapped Program Fetch Cache

This block sits between a processor's instruction fetch port and an external memory. Each request asks for a 256-bit fetch packet, which is eight 32-bit instructions on a 32-byte boundary. The cache has one frame for each index value, so it is direct-mapped. Beside each frame it stores a tag and a valid flag. On a hit the packet comes back on the next clock. On a miss the block stalls the fetch port and reads the eight words from external memory one at a time. It then records the new tag, marks the frame valid, and returns the complete packet.

An enable input selects between cache operation and a mode in which the cache is bypassed. The bypass mode itself is handled outside this block. When the enable changes from low to high, the block walks every frame and clears its valid flag, one frame per cycle. Fetch requests are refused until that walk finishes.

Top module: `fetch_cache`

## Requirements
- R1: The request address is split into three fields. Bits 4..0 are ignored. Bits 15..5 form the 11-bit frame index. Bits 25..16 form the 10-bit tag. Bits 31..26 take no part in the lookup. Every external read address has bits 31..26 and bits 1..0 equal to zero.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. If it hits, `rsp_valid` is high for exactly one cycle after that edge. Bits 32k+31..32k of `rsp_data` hold the memory word at packet base + 4k, for k from 0 to 7.
- R3: A miss is detected when the indexed entry is invalid or its stored tag differs from the request tag. During a miss `req_ready` stays low until the packet has been returned.
- R4: During a fill `mem_req` is high. `mem_addr` starts at the packet base and steps by 4 only after a cycle in which `mem_dvalid` was high. Otherwise it holds its value.
- R5: A missed packet is returned one cycle after the eighth data beat is taken, and no earlier.
- R6: After a fill, a request for the same packet hits and issues no external reads.
- R7: Two packets whose addresses differ by a multiple of 64 KB share a frame. Fetching one evicts the other.
- R8: When `cache_en` changes from 0 to 1, every valid flag is cleared. `req_ready` stays low for 2048 cycles after the edge where the change is seen. Every earlier packet then misses.
- R9: While `cache_en` is low, `req_ready` is low. No lookup and no external read takes place.
- R10: After reset, `req_ready`, `rsp_valid` and `mem_req` are low and every frame is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_en | input | 1 | 1 = cache operation; a rising edge starts the invalidation walk |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 32 | Fetch byte address |
| req_ready | output | 1 | Request can be accepted |
| rsp_valid | output | 1 | Packet valid, one cycle |
| rsp_data | output | 256 | Eight instruction words, word 0 in the low bits |
| mem_req | output | 1 | External word read requested |
| mem_addr | output | 32 | External word byte address |
| mem_dvalid | input | 1 | External data word present this cycle |
| mem_data | input | 32 | External data word |

## Verification
The assertions assume that external memory returns the word for the address currently on `mem_addr`, and only while `mem_req` is high. They also assume that `cache_en` does not change while a fill is in progress. The bench keeps to both assumptions. It drives `mem_dvalid` with random gaps, and only in cycles where it has just seen `mem_req` high. It changes the enable only while the port is idle. Requests are issued one at a time, and a new one starts only after the previous packet has returned.

// File: rtl/fc_pkg.sv
package fc_pkg;
    localparam int WORD_W = 32;
    localparam int WORDS  = 8;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 11;
    localparam int TAG_W  = 10;
    localparam int LINE_W = WORD_W * WORDS;
    localparam int BEAT_W = $clog2(WORDS);
    localparam int OFF_W  = $clog2(LINE_W / 8);
    localparam int FRAMES = 1 << IDX_W;
    localparam int PAD_W  = ADDR_W - TAG_W - IDX_W - OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_FLUSH
    } fc_state_e;

    typedef struct packed {
        fc_state_e          state;
        logic               en;
        logic               flush_pend;
        logic [IDX_W-1:0]   idx;
        logic [TAG_W-1:0]   tag;
        logic [BEAT_W-1:0]  beat;
        logic [IDX_W-1:0]   fcnt;
        logic [LINE_W-1:0]  line;
        logic               rsp_v;
        logic [LINE_W-1:0]  rsp;
    } fc_regs_t;
endpackage

// File: rtl/fc_tag_store.sv
module fc_tag_store #(
    parameter int IDX_W = 11,
    parameter int TAG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tags_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    assign rd_tag = tags_q[rd_idx];
    assign rd_vld = vld_q[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags_q[wr_idx] <= wr_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (clr_en) begin
                vld_q[clr_idx] <= 1'b0;
            end
            if (wr_en) begin
                vld_q[wr_idx] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fc_line_store.sv
module fc_line_store #(
    parameter int IDX_W  = 11,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int DEPTH = 1 << IDX_W;

    logic [LINE_W-1:0] mem_q [DEPTH];

    assign rd_line = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_line;
        end
    end
endmodule

// File: rtl/fetch_cache.sv
module fetch_cache
    import fc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_en,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_dvalid,
    input  logic [WORD_W-1:0] mem_data
);
    fc_regs_t r_q, r_d;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [TAG_W-1:0]  rd_tag;
    logic              rd_vld;
    logic [LINE_W-1:0] rd_line;
    logic              hit;
    logic              en_rise;
    logic              wr_en;
    logic              clr_en;
    logic [LINE_W-1:0] line_next;

    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[OFF_W + IDX_W +: TAG_W];

    fc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (req_idx),
        .rd_tag  (rd_tag),
        .rd_vld  (rd_vld),
        .wr_en   (wr_en),
        .wr_idx  (r_q.idx),
        .wr_tag  (r_q.tag),
        .clr_en  (clr_en),
        .clr_idx (r_q.fcnt)
    );

    fc_line_store #(.IDX_W(IDX_W), .LINE_W(LINE_W)) u_lines (
        .clk     (clk),
        .rd_idx  (req_idx),
        .rd_line (rd_line),
        .wr_en   (wr_en),
        .wr_idx  (r_q.idx),
        .wr_line (line_next)
    );

    assign hit       = rd_vld && (rd_tag == req_tag);
    assign en_rise   = cache_en && !r_q.en;
    assign req_ready = (r_q.state == ST_IDLE) && cache_en && r_q.en && !r_q.flush_pend;
    assign rsp_valid = r_q.rsp_v;
    assign rsp_data  = r_q.rsp;
    assign mem_req   = (r_q.state == ST_FILL);
    assign mem_addr  = {{PAD_W{1'b0}}, r_q.tag, r_q.idx, r_q.beat, 2'b00};

    always_comb begin
        r_d       = r_q;
        r_d.rsp_v = 1'b0;
        r_d.en    = cache_en;
        wr_en     = 1'b0;
        clr_en    = 1'b0;
        line_next = r_q.line;
        line_next[r_q.beat*WORD_W +: WORD_W] = mem_data;
        if (en_rise) begin
            r_d.flush_pend = 1'b1;
        end
        unique case (r_q.state)
            ST_IDLE: begin
                if (r_q.flush_pend || en_rise) begin
                    r_d.state      = ST_FLUSH;
                    r_d.fcnt       = '0;
                    r_d.flush_pend = 1'b0;
                end else if (req_valid && req_ready) begin
                    if (hit) begin
                        r_d.rsp_v = 1'b1;
                        r_d.rsp   = rd_line;
                    end else begin
                        r_d.state = ST_FILL;
                        r_d.idx   = req_idx;
                        r_d.tag   = req_tag;
                        r_d.beat  = '0;
                    end
                end
            end
            ST_FILL: begin
                if (mem_dvalid) begin
                    r_d.line = line_next;
                    r_d.beat = r_q.beat + 1'b1;
                    if (r_q.beat == BEAT_W'(WORDS - 1)) begin
                        wr_en     = 1'b1;
                        r_d.rsp_v = 1'b1;
                        r_d.rsp   = line_next;
                        r_d.state = ST_IDLE;
                    end
                end
            end
            ST_FLUSH: begin
                clr_en   = 1'b1;
                r_d.fcnt = r_q.fcnt + 1'b1;
                if (r_q.fcnt == IDX_W'(FRAMES - 1)) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/fc_checker.sv
module fc_checker
    import fc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cache_en,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_dvalid
);
    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00) && (mem_addr[ADDR_W-1:TAG_W+IDX_W+OFF_W] == '0)); // R1
    AST_STALL_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req) && $past(mem_dvalid)) |-> (mem_addr == $past(mem_addr) + 32'd4)); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req) && !$past(mem_dvalid)) |-> $stable(mem_addr)); // R4
    AST_RSP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(mem_req)) |-> ($past(mem_dvalid) && ($past(mem_addr[4:2]) == 3'd7))); // R5
    AST_FLUSH_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cache_en) |=> !req_ready); // R8
    AST_OFF_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !cache_en |-> !req_ready); // R9
endmodule

bind fetch_cache fc_checker u_fc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cache_en   (cache_en),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_dvalid (mem_dvalid)
);

// File: tb/fetch_cache_tb_top.sv
module fetch_cache_tb_top;
    localparam int NFR = 2048;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cache_en = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_ready;
    logic         rsp_valid;
    logic [255:0] rsp_data;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_dvalid = 1'b0;
    logic [31:0]  mem_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    int n_hit = 0;
    int n_miss = 0;

    bit       vld_m [NFR];
    bit [9:0] tag_m [NFR];

    always #4 clk = ~clk;

    fetch_cache dut_i (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_dvalid(mem_dvalid), .mem_data(mem_data)
    );

    function automatic logic [31:0] ref_word(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A3C_0F17;
    endfunction

    function automatic logic [255:0] ref_line(logic [31:0] a);
        logic [255:0] l;
        logic [31:0]  base;
        base = {6'b0, a[25:5], 5'b0};
        for (int k = 0; k < 8; k++) l[32*k +: 32] = ref_word(base + 32'(4*k));
        return l;
    endfunction

    task automatic chk(string r, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic model_flush();
        for (int i = 0; i < NFR; i++) vld_m[i] = 1'b0;
    endtask

    task automatic do_req(logic [31:0] a);
        int cyc, beats, lastc;
        bit exp_hit;
        logic [31:0] base;
        base = {6'b0, a[25:5], 5'b0};
        exp_hit = vld_m[a[15:5]] && (tag_m[a[15:5]] == a[25:16]);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1; beats = 0; lastc = 0;
        while (!rsp_valid && cyc < 200) begin
            mem_dvalid = 1'b0;
            chk("R3 ready low while fill pending", req_ready, 0);
            if (mem_req) begin
                chk("R4 external word address", mem_addr, base + 32'(4*beats));
                if (($urandom % 4) != 0 && beats < 8) begin
                    mem_dvalid = 1'b1;
                    mem_data   = ref_word(mem_addr);
                    beats++;
                    lastc = cyc;
                end
            end
            @(negedge clk);
            cyc++;
        end
        mem_dvalid = 1'b0;
        chk("R2 packet data", rsp_data, ref_line(a));
        if (exp_hit) begin
            n_hit++;
            chk("R2 R6 hit latency", cyc, 1);
            chk("R6 no reads on hit", beats, 0);
        end else begin
            n_miss++;
            chk("R5 eight beats before packet", beats, 8);
            chk("R5 packet one cycle after last beat", cyc, lastc + 1);
            vld_m[a[15:5]] = 1'b1;
            tag_m[a[15:5]] = a[25:16];
        end
        @(negedge clk);
        chk("R2 single-cycle response", rsp_valid, 0);
    endtask

    task automatic enable_and_walk();
        int lo;
        @(negedge clk);
        cache_en = 1'b1;
        #0;
        chk("R8 ready low at enable edge", req_ready, 0);
        lo = 0;
        @(negedge clk);
        while (!req_ready && lo < 5000) begin
            lo++;
            @(negedge clk);
        end
        chk("R8 walk length", lo, NFR);
        model_flush();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [31:0] a;
        int hb, mb;
        model_flush();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ready", req_ready, 0);
        chk("R10 reset rsp_valid", rsp_valid, 0);
        chk("R10 reset mem_req", mem_req, 0);
        req_valid = 1'b1;
        req_addr  = 32'h0000_1240;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9 disabled ready", req_ready, 0);
            chk("R9 disabled no read", mem_req, 0);
        end
        req_valid = 1'b0;
        enable_and_walk();

        a = 32'h0000_1240;
        do_req(a);
        chk("R10 first fetch after reset misses", n_miss, 1);
        do_req(a);
        chk("R6 refetch hits", n_hit, 1);
        do_req(a | 32'h0000_001F);
        chk("R1 low bits ignored", n_hit, 2);
        do_req(a | 32'hFC00_0000);
        chk("R1 upper bits ignored", n_hit, 3);
        do_req(a + 32'h0001_0000);
        chk("R7 alias misses", n_miss, 2);
        do_req(a);
        chk("R7 original evicted", n_miss, 3);
        do_req(a + 32'h0003_0000);
        chk("R7 alias 192KB misses", n_miss, 4);

        for (int i = 0; i < 40; i++) begin
            a = {6'b0, 5'($urandom % 4), 4'($urandom), 17'($urandom)};
            do_req(a);
        end

        hb = n_hit; mb = n_miss;
        do_req(32'h0000_1240 + 32'h0003_0000);
        @(negedge clk);
        cache_en = 1'b0;
        req_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R9 off no ready", req_ready, 0);
            chk("R9 off no read", mem_req, 0);
        end
        req_valid = 1'b0;
        enable_and_walk();
        mb = n_miss;
        do_req(32'h0000_1240 + 32'h0003_0000);
        chk("R8 miss after walk", n_miss, mb + 1);
        chk("R8 no hit after walk", n_hit >= hb, 1);
        summary();
    end
endmodule